// File: doc/BRIEF.md
# Source-Aware Reference Tick Generator

This block turns the peripheral bus clock into a slow reference tick whose rate does not move when the CPU clock source changes. The bus clock is the block's clock, and a bus-clock enable marks the cycles in which the bus clock really advances. Each CPU clock source changes the bus clock frequency. Software therefore programs one divisor for each source. The block picks the divisor that matches the source code currently in force. Timers and serial links that count the tick keep their timing across a source switch without being reprogrammed.

The divisors are written through a simple write port, addressed by the same source code. A tick is a single-cycle enable that rises once every (divisor + 1) enabled bus cycles. A source change restarts the count at once with the new source's divisor. A divisor rewritten while its source is active takes effect only after the period in progress has finished, so the tick never has one short or mixed period. Multiplexing of the clocks themselves is outside this block.

Top module: `refTickGen`

## Requirements
- R1: While reset is asserted `tickEn` is low. After reset every divisor and the period counter are zero, and the selected source is code 0.
- R2: For the active source with divisor value d, `tickEn` rises on every (d+1)-th enabled cycle after a restart. This holds for every d from 0 to 255.
- R3: `tickEn` is high only in a cycle where `busEn` is high, and only for that one cycle.
- R4: Cycles with `busEn` low neither advance the period count nor produce a tick, however many of them there are.
- R5: A divisor of 0 gives a tick on every enabled cycle.
- R6: Each source code has its own divisor: 0 crystal, 1 main PLL, 2 fast RC oscillator, 3 audio PLL. A write with `wrEn` high stores `wrData` in the divisor whose code equals `wrAddr`. The divisor in use is the one whose code equals `srcSel`.
- R7: In the cycle where `srcSel` differs from the previous cycle's code, no tick is produced, even with `busEn` high. The count restarts from zero with the new source's divisor, and that cycle's enable is not counted.
- R8: A write to the active source's divisor changes nothing in the period in progress. The period still ends after the old count, and the next period uses the new value.
- R9: A write to a divisor of an inactive source leaves the current tick sequence untouched. The new value is used once that source is selected.
- R10: With the main PLL source and a divisor of 79, a tick comes every 80 enabled cycles. At an 80 MHz bus clock this is a 1 MHz tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busEn | input | 1 | Bus-clock enable; high in cycles that count |
| srcSel | input | 2 | Code of the active CPU clock source |
| wrEn | input | 1 | Divisor write strobe |
| wrAddr | input | 2 | Source code of the divisor being written |
| wrData | input | 8 | Divisor value to write |
| tickEn | output | 1 | One-cycle reference tick |

## Verification
`tickEn` is a combinational result of the registered count and the current `busEn` and `srcSel`. The bench therefore drives each input set just after a falling edge and samples the tick one time unit later, within the same cycle. A divisor write or a source change shows up in `tickEn` from the next cycle on: the change cycle itself must show no tick, and the first new tick is due after d+1 enabled cycles. The bench counts enabled cycles from each restart and expects a tick exactly where that count modulo (d+1) equals d. For R8 it changes d only after the old period's tick.

// File: rtl/refTickPkg.sv
package refTickPkg;
  // strobes from control to datapath, at most one set per cycle
  typedef struct packed {
    logic restart;  // source changed: clear count, load new source's divisor
    logic reload;   // period finished on an enabled cycle: clear count, reload divisor
    logic advance;  // enabled cycle inside the period: count up
  } tickCtl_t;
endpackage

// File: rtl/refTickDatapath.sv
module refTickDatapath
  import refTickPkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int NUM_SRC = 4,
  parameter int SEL_W   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  tickCtl_t         ctl,
  input  logic [SEL_W-1:0] srcSel,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrAddr,
  input  logic [DIV_W-1:0] wrData,
  output logic             atEnd,
  output logic [DIV_W-1:0] cntVal,
  output logic [DIV_W-1:0] curDiv
);
  logic [DIV_W-1:0] divReg [NUM_SRC];
  logic [DIV_W-1:0] selDiv;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_div
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        divReg[g] <= '0;
      end else if (wrEn && (wrAddr == SEL_W'(g))) begin
        divReg[g] <= wrData;
      end
    end
  end

  assign selDiv = divReg[srcSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal <= '0;
      curDiv <= '0;
    end else if (ctl.restart || ctl.reload) begin
      cntVal <= '0;
      curDiv <= selDiv;
    end else if (ctl.advance) begin
      cntVal <= cntVal + DIV_W'(1);
    end
  end

  assign atEnd = (cntVal == curDiv);
endmodule

// File: rtl/refTickControl.sv
module refTickControl
  import refTickPkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busEn,
  input  logic [SEL_W-1:0] srcSel,
  input  logic             atEnd,
  output tickCtl_t         ctl,
  output logic             tickEn
);
  logic [SEL_W-1:0] srcReg;
  logic             srcChange;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcReg <= '0;
    end else begin
      srcReg <= srcSel;
    end
  end

  assign srcChange = (srcSel != srcReg);

  always_comb begin
    ctl.restart = srcChange;
    ctl.reload  = busEn && atEnd && !srcChange;
    ctl.advance = busEn && !atEnd && !srcChange;
  end

  assign tickEn = rstN && ctl.reload;
endmodule

// File: rtl/refTickGen.sv
module refTickGen
  import refTickPkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int NUM_SRC = 4,
  localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busEn,
  input  logic [SEL_W-1:0] srcSel,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrAddr,
  input  logic [DIV_W-1:0] wrData,
  output logic             tickEn
);
  tickCtl_t         ctl;
  logic             atEnd;
  logic [DIV_W-1:0] cntVal;
  logic [DIV_W-1:0] curDiv;

  refTickControl #(.SEL_W(SEL_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .busEn  (busEn),
    .srcSel (srcSel),
    .atEnd  (atEnd),
    .ctl    (ctl),
    .tickEn (tickEn)
  );

  refTickDatapath #(.DIV_W(DIV_W), .NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .srcSel (srcSel),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .atEnd  (atEnd),
    .cntVal (cntVal),
    .curDiv (curDiv)
  );
endmodule

// File: rtl/refTickChecker.sv
module refTickChecker #(
  parameter int DIV_W = 8,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             busEn,
  input logic [SEL_W-1:0] srcSel,
  input logic             tickEn,
  input logic [DIV_W-1:0] cntVal,
  input logic [DIV_W-1:0] curDiv
);
  logic [SEL_W-1:0] prevSrc;
  logic             srcSame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevSrc <= '0;
    else       prevSrc <= srcSel;
  end

  assign srcSame = (srcSel == prevSrc);

  always_comb begin
    if (!rstN) begin
      AST_RESET_QUIET: assert (!tickEn); // R1
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cntVal <= curDiv); // R2

  AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    tickEn |-> busEn); // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!busEn && srcSame) |=> $stable(cntVal)); // R4

  AST_ZERO_DIV_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (busEn && srcSame && curDiv == '0) |-> tickEn); // R5

  AST_NO_TICK_ON_SWITCH: assert property (@(posedge clk) disable iff (!rstN)
    !srcSame |-> !tickEn); // R7

  AST_SWITCH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !srcSame |=> cntVal == '0); // R7
endmodule

bind refTickGen refTickChecker #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .busEn  (busEn),
  .srcSel (srcSel),
  .tickEn (tickEn),
  .cntVal (cntVal),
  .curDiv (curDiv)
);

// File: tb/test_refTickGen.sv
module test_refTickGen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       busEn;
  logic [1:0] srcSel;
  logic       wrEn;
  logic [1:0] wrAddr;
  logic [7:0] wrData;
  logic       tickEn;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refTickGen i_refTickGen (
    .clk(clk), .rstN(rstN), .busEn(busEn), .srcSel(srcSel),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .tickEn(tickEn)
  );

  task automatic check(input logic exp, input string tag);
    nChecks++;
    if (tickEn !== exp) begin
      nFail++;
      $display("FAIL %s: tickEn=%0b expected %0b at %0t", tag, tickEn, exp, $time);
    end
  endtask

  task automatic step(input logic en, input logic exp, input string tag);
    @(negedge clk);
    busEn = en; wrEn = 1'b0;
    #1 check(exp, tag);
  endtask

  task automatic switchSrc(input logic [1:0] s, input logic en, input string tag);
    @(negedge clk);
    srcSel = s; busEn = en; wrEn = 1'b0;
    #1 check(1'b0, tag);
  endtask

  task automatic wrDiv(input logic [1:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    busEn = 1'b0; wrEn = 1'b1; wrAddr = a; wrData = d;
    #1 check(1'b0, tag);
  endtask

  // count enabled cycles from a fresh period; tick due when n mod (d+1) == d
  task automatic runEn(input int d, input int enables, input int pat, input string tag);
    int n = 0;
    int cyc = 0;
    while (n < enables) begin
      logic en;
      logic exp;
      en  = (pat == 0) || (cyc % 3 != 1);
      exp = en && ((n % (d + 1)) == d);
      step(en, exp, tag);
      if (en) n++;
      cyc++;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int dv [4];
    dv[0] = 3; dv[1] = 5; dv[2] = 2; dv[3] = 7;
    rstN = 1'b0; busEn = 1'b1; srcSel = 2'd0; wrEn = 1'b0; wrAddr = 2'd0; wrData = 8'd0;
    // R1: quiet in reset even with busEn high
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1 check(1'b0, "R1");
    end
    @(negedge clk); rstN = 1'b1;
    // R1/R5: divisors reset to zero, tick every enable
    runEn(0, 5, 0, "R5");
    runEn(0, 6, 1, "R5");

    // R6: program each source's divisor, then visit each source
    for (int s = 0; s < 4; s++) wrDiv(2'(s), 8'(dv[s]), "R6");
    begin
      int order [4];
      order[0] = 1; order[1] = 2; order[2] = 3; order[3] = 0;
      for (int k = 0; k < 4; k++) begin
        switchSrc(2'(order[k]), 1'b0, "R7");
        runEn(dv[order[k]], 3 * (dv[order[k]] + 1), k % 2, "R6");
      end
    end

    // R7: switch in mid-period with busEn high
    switchSrc(2'd1, 1'b0, "R7");
    runEn(5, 3, 0, "R7");
    switchSrc(2'd2, 1'b1, "R7");
    runEn(2, 6, 0, "R7");

    // R8: rewrite active divisor mid-period
    runEn(2, 1, 0, "R8");
    wrDiv(2'd2, 8'd6, "R8");
    step(1'b1, 1'b0, "R8");
    step(1'b1, 1'b1, "R8");
    runEn(6, 14, 1, "R8");

    // R9: write an inactive source's divisor
    runEn(6, 3, 0, "R9");
    wrDiv(2'd3, 8'd9, "R9");
    for (int n = 3; n <= 6; n++) step(1'b1, n == 6, "R9");
    runEn(6, 7, 0, "R9");
    switchSrc(2'd3, 1'b0, "R9");
    runEn(9, 20, 0, "R9");

    // R4: long idle stretch inside a period
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, "R4");
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0, "R4");
    for (int i = 0; i < 6; i++) step(1'b1, i == 5, "R4");

    // R2: sweep of divisor values on source 1
    for (int d = 0; d < 16; d++) begin
      wrDiv(2'd1, 8'(d), "R2");
      switchSrc(2'd0, 1'b0, "R2");
      switchSrc(2'd1, 1'b0, "R2");
      runEn(d, 3 * (d + 1), d % 2, "R2");
    end

    // R10: divisor 79 on the main PLL source
    wrDiv(2'd1, 8'd79, "R10");
    switchSrc(2'd0, 1'b0, "R10");
    switchSrc(2'd1, 1'b0, "R10");
    runEn(79, 160, 0, "R10");

    // R2: largest divisor
    wrDiv(2'd1, 8'd255, "R2");
    switchSrc(2'd0, 1'b0, "R2");
    switchSrc(2'd1, 1'b0, "R2");
    runEn(255, 256, 0, "R2");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule